// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks a DMA channel through a block of memory one element at a time. A data mover pulses a strobe each time it finishes an element. On each strobe the block advances the current address by a signed per-element step and counts down the elements left in the current row. In two-dimensional mode, a row that runs out moves the address by a signed row step, reloads the row count and counts down the rows. It does not fetch memory and does not parse descriptors.

When the whole block is finished, the flow mode decides what comes next. Flow mode 0 stops the channel and raises a done flag. Any other flow mode keeps the channel running and raises a request for the next descriptor. The surrounding logic answers that request by presenting new programmed values with another load pulse. While the request is pending, the element-ready output is low and element strobes are held off. Each row that empties can also raise a one-cycle interrupt pulse.

A load pulse captures the programmed values. It also checks that the per-element step matches the element size in magnitude. A mismatch is reported as a configuration error and the channel is not started.

Top module: `dma2d_agen`

## Requirements
- R1: One cycle after a `load` pulse with a valid configuration, the outputs hold these values: `cur_addr` equals `prog_addr`; `cur_xcnt` and `cur_ycnt` hold the programmed counts, with a programmed 0 meaning the all-ones maximum; `running` is 1; `done`, `desc_req`, `cfg_err` and `irq` are 0.
- R2: An accepted element strobe (`elem_stb` while `elem_rdy`) with `cur_xcnt` above 1 adds the sign-extended `prog_xmod` to `cur_addr` and decrements `cur_xcnt`. Both changes are visible on the next cycle.
- R3: An accepted strobe with `cur_xcnt` equal to 1 is a row end when 2D mode (`prog_two_d`=1) is set and `cur_ycnt` is above 1. At a row end, `cur_ycnt` decrements and `cur_xcnt` reloads the programmed row count. `cur_addr` becomes the address before the strobe plus the sign-extended `prog_ymod`, which equals stepping by X, backing that step out, and adding the Y step.
- R4: `irq` is high for exactly the one cycle after an accepted strobe that empties the X count, and only when `prog_irq_en` was 1 at load. It is low at all other times.
- R5: An accepted strobe with `cur_xcnt` equal to 1 that is not a row end ends the block. The address steps by X and `cur_xcnt` becomes 0. In flow mode 0 (`prog_flow`=2'b00), `running` falls and `done` rises on the next cycle.
- R6: At the end of a block in flow modes 1, 2 and 3, `desc_req` rises, `running` stays 1 and `elem_rdy` falls. `elem_rdy` equals `running` and not `desc_req`. Strobes while `elem_rdy` is low change neither the address nor the counters.
- R7: On a load, element size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 reserved. If the code is 3, or the magnitude of `prog_xmod` differs from the element size in bytes, `cfg_err` is 1 and `running` is 0 on the next cycle.
- R8: A `halt` pulse clears `running` and `desc_req` on the next cycle. `done` keeps its value. Later strobes are ignored.
- R9: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture the programmed values and start (or restart) the channel |
| halt | input | 1 | Stop the channel |
| prog_addr | input | ADDR_W | Start address |
| prog_xcnt | input | CNT_W | Elements per row (0 means maximum) |
| prog_xmod | input | MOD_W | Signed per-element address step |
| prog_ycnt | input | CNT_W | Rows per block (0 means maximum) |
| prog_ymod | input | MOD_W | Signed row-end address step |
| prog_two_d | input | 1 | 2D mode enable |
| prog_irq_en | input | 1 | Row-end interrupt enable |
| prog_flow | input | 2 | Flow mode: 0 stops at block end, others chain |
| prog_esize | input | 2 | Element size code |
| elem_stb | input | 1 | Element completed by the data mover |
| elem_rdy | output | 1 | Element strobes are accepted |
| cur_addr | output | ADDR_W | Current address |
| cur_xcnt | output | CNT_W | Elements left in the current row |
| cur_ycnt | output | CNT_W | Rows left in the block |
| running | output | 1 | Channel active |
| done | output | 1 | Block finished in stop flow mode |
| cfg_err | output | 1 | Last load had an invalid stride or size |
| desc_req | output | 1 | Next descriptor requested |
| irq | output | 1 | One-cycle row-end interrupt |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=3 and MOD_W=8. The 3-bit counts bring every row length and row count within reach, including the zero-means-maximum encoding at 7. With these widths the bench can sweep every element size, both stride signs, both dimensionalities and both kinds of flow mode through whole blocks element by element. The narrow address makes sign extension of negative steps and address wrap visible. The 8-bit modifier lets the bench try every small stride around each element size for the configuration-error check.

// File: rtl/dma2d_pkg.sv
// Shared encodings for the 2D DMA address generator.
// Assumes the flow and element size codes come straight from the descriptor fields.
package dma2d_pkg;

    typedef enum logic [1:0] {
        FLOW_STOP    = 2'b00,
        FLOW_RELOAD  = 2'b01,
        FLOW_CHAIN_S = 2'b10,
        FLOW_CHAIN_L = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_RSVD = 2'b11
    } esize_e;

    typedef struct packed {
        logic  two_d;
        logic  irq_en;
        flow_e flow;
    } mode_t;

endpackage

// File: rtl/dma2d_cfg_check.sv
// Stride checker: flags a configuration whose element step does not match the
// element size in magnitude, or whose size code is reserved.
// Assumes MOD_W is at least 4, so a 4-byte size fits.
module dma2d_cfg_check
    import dma2d_pkg::*;
#(
    parameter int MOD_W = 16
) (
    input  logic [1:0]              esize,
    input  logic signed [MOD_W-1:0] xmod,
    output logic                    bad
);

    logic [MOD_W-1:0] mag;
    logic [MOD_W-1:0] want;

    // Compare the step magnitude with the byte count of the element size.
    always_comb begin
        mag  = xmod[MOD_W-1] ? $unsigned(-xmod) : $unsigned(xmod);
        want = MOD_W'(1) << esize;
        bad  = (esize_e'(esize) == ESZ_RSVD) || (mag != want);
    end

endmodule

// File: rtl/dma2d_counters.sv
// Row and column counters: count down the elements of a row and the rows of a block.
// Reports whether an accepted element ends a row or the whole block.
// Assumes step is never high while cur_x is 0; the top gates it with the run state.
module dma2d_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_x,
    input  logic [CNT_W-1:0] ld_y,
    input  logic             two_d,
    input  logic             step,
    output logic [CNT_W-1:0] cur_x,
    output logic [CNT_W-1:0] cur_y,
    output logic             last_elem,
    output logic             row_wrap,
    output logic             block_end
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] x_prog;

    function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_MAX : c;
    endfunction

    assign last_elem = step && (cur_x == CNT_ONE);
    assign row_wrap  = last_elem && two_d && (cur_y > CNT_ONE);
    assign block_end = last_elem && !row_wrap;

    // Count state: load, row reload with row decrement, or column decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x  <= '0;
            cur_y  <= '0;
            x_prog <= '0;
        end else if (load) begin
            cur_x  <= eff_cnt(ld_x);
            cur_y  <= eff_cnt(ld_y);
            x_prog <= eff_cnt(ld_x);
        end else if (row_wrap) begin
            cur_y <= cur_y - CNT_ONE;
            cur_x <= x_prog;
        end else if (step) begin
            cur_x <= cur_x - CNT_ONE;
        end
    end

    // R2: a step inside a row takes one off the column count.
    p_xdec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cur_x > CNT_ONE) && !load) |=> (cur_x == $past(cur_x) - CNT_ONE));

    // R3: a row end reloads the columns and takes one off the rows.
    p_rowload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wrap && !load) |=> ((cur_x == x_prog) && (cur_y == $past(cur_y) - CNT_ONE)));

    // R5: the last element of a block empties the column count.
    p_blockzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end && !load) |=> (cur_x == '0));

endmodule

// File: rtl/dma2d_addr.sv
// Address register: holds the current address and moves it by the signed
// element step, or by the signed row step at the end of a row.
// Assumes ADDR_W >= MOD_W; the steps are sign-extended to the address width.
module dma2d_addr #(
    parameter int ADDR_W = 32,
    parameter int MOD_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic signed [MOD_W-1:0] ld_xmod,
    input  logic signed [MOD_W-1:0] ld_ymod,
    input  logic                    step,
    input  logic                    row_wrap,
    output logic [ADDR_W-1:0]       cur_addr
);

    logic signed [MOD_W-1:0] xmod_q;
    logic signed [MOD_W-1:0] ymod_q;
    logic [ADDR_W-1:0]       xstep;
    logic [ADDR_W-1:0]       ystep;

    // Sign-extend both steps to the address width.
    assign xstep = ADDR_W'(xmod_q);
    assign ystep = ADDR_W'(ymod_q);

    // Address update. A row end uses the net of (+X, -X, +Y), which is just +Y.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            xmod_q   <= '0;
            ymod_q   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            xmod_q   <= ld_xmod;
            ymod_q   <= ld_ymod;
        end else if (row_wrap) begin
            cur_addr <= cur_addr + ystep;
        end else if (step) begin
            cur_addr <= cur_addr + xstep;
        end
    end

    // R2: an ordinary step adds the element step.
    p_xstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !row_wrap && !load) |=> (cur_addr == $past(cur_addr) + $past(xstep)));

    // R3: a row end adds only the row step.
    p_ywrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wrap && !load) |=> (cur_addr == $past(cur_addr) + $past(ystep)));

endmodule

// File: rtl/dma2d_agen.sv
// 2D DMA address generator top: channel run state, block-end handling by flow
// mode, row-end interrupt, and hold-off of element strobes while a new
// descriptor is awaited.
// Assumes the descriptor parser answers desc_req with a load pulse carrying
// the next programmed values; load takes priority over halt.
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int MOD_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    halt,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [CNT_W-1:0]        prog_xcnt,
    input  logic signed [MOD_W-1:0] prog_xmod,
    input  logic [CNT_W-1:0]        prog_ycnt,
    input  logic signed [MOD_W-1:0] prog_ymod,
    input  logic                    prog_two_d,
    input  logic                    prog_irq_en,
    input  logic [1:0]              prog_flow,
    input  logic [1:0]              prog_esize,
    input  logic                    elem_stb,
    output logic                    elem_rdy,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic [CNT_W-1:0]        cur_xcnt,
    output logic [CNT_W-1:0]        cur_ycnt,
    output logic                    running,
    output logic                    done,
    output logic                    cfg_err,
    output logic                    desc_req,
    output logic                    irq
);

    mode_t mode_q;
    logic  step;
    logic  last_elem;
    logic  row_wrap;
    logic  block_end;
    logic  cfg_bad;

    // Strobes are taken only while running and not waiting on a descriptor.
    assign elem_rdy = running && !desc_req;
    assign step     = elem_stb && elem_rdy;

    dma2d_cfg_check #(.MOD_W(MOD_W)) u_check (
        .esize (prog_esize),
        .xmod  (prog_xmod),
        .bad   (cfg_bad)
    );

    dma2d_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_x      (prog_xcnt),
        .ld_y      (prog_ycnt),
        .two_d     (mode_q.two_d),
        .step      (step),
        .cur_x     (cur_xcnt),
        .cur_y     (cur_ycnt),
        .last_elem (last_elem),
        .row_wrap  (row_wrap),
        .block_end (block_end)
    );

    dma2d_addr #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_addr  (prog_addr),
        .ld_xmod  (prog_xmod),
        .ld_ymod  (prog_ymod),
        .step     (step),
        .row_wrap (row_wrap),
        .cur_addr (cur_addr)
    );

    // Channel control: start on load, stop on halt, and at block end either finish or request a chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            running  <= 1'b0;
            done     <= 1'b0;
            cfg_err  <= 1'b0;
            desc_req <= 1'b0;
            irq      <= 1'b0;
        end else if (load) begin
            mode_q   <= '{two_d: prog_two_d, irq_en: prog_irq_en, flow: flow_e'(prog_flow)};
            running  <= !cfg_bad;
            cfg_err  <= cfg_bad;
            done     <= 1'b0;
            desc_req <= 1'b0;
            irq      <= 1'b0;
        end else if (halt) begin
            running  <= 1'b0;
            desc_req <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= last_elem && mode_q.irq_en;
            if (block_end) begin
                if (mode_q.flow == FLOW_STOP) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    desc_req <= 1'b1;
                end
            end
        end
    end

    // R4: an emptied row with the interrupt enabled pulses irq next cycle.
    p_irq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_elem && mode_q.irq_en && !load && !halt) |=> irq);

    // R4: irq never appears without an emptied row in the cycle before.
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(last_elem));

    // R5: a finished channel is not running.
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    // R6: while a descriptor is awaited the address and counters hold.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !load) |=> ($stable(cur_addr) && $stable(cur_xcnt) && $stable(cur_ycnt)));

    // R7: a rejected configuration leaves the channel stopped.
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !running);

    // R8: a halt stops the channel on the next cycle.
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> (!running && !desc_req));

endmodule

// File: tb/tb_dma2d_agen.sv
// Bench for the 2D DMA address generator: sweeps small configurations over
// whole blocks and compares against expected values computed from the requirements.
module tb_dma2d_agen;

    localparam int AW = 16;
    localparam int CW = 3;
    localparam int MW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 load = 1'b0;
    logic                 halt = 1'b0;
    logic [AW-1:0]        prog_addr = '0;
    logic [CW-1:0]        prog_xcnt = '0;
    logic signed [MW-1:0] prog_xmod = '0;
    logic [CW-1:0]        prog_ycnt = '0;
    logic signed [MW-1:0] prog_ymod = '0;
    logic                 prog_two_d = 1'b0;
    logic                 prog_irq_en = 1'b0;
    logic [1:0]           prog_flow = '0;
    logic [1:0]           prog_esize = '0;
    logic                 elem_stb = 1'b0;
    logic                 elem_rdy;
    logic [AW-1:0]        cur_addr;
    logic [CW-1:0]        cur_xcnt;
    logic [CW-1:0]        cur_ycnt;
    logic                 running, done, cfg_err, desc_req, irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Expected state.
    logic [AW-1:0]        ea;
    logic [CW-1:0]        ex, ey, exprog;
    logic                 erun, edone, ecfg, ereq, eirq;
    logic                 m2d, mien;
    logic [1:0]           mflow;
    logic signed [MW-1:0] mxm, mym;

    always #10 clk = ~clk;

    dma2d_agen #(.ADDR_W(AW), .CNT_W(CW), .MOD_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .halt(halt),
        .prog_addr(prog_addr), .prog_xcnt(prog_xcnt), .prog_xmod(prog_xmod),
        .prog_ycnt(prog_ycnt), .prog_ymod(prog_ymod), .prog_two_d(prog_two_d),
        .prog_irq_en(prog_irq_en), .prog_flow(prog_flow), .prog_esize(prog_esize),
        .elem_stb(elem_stb), .elem_rdy(elem_rdy), .cur_addr(cur_addr),
        .cur_xcnt(cur_xcnt), .cur_ycnt(cur_ycnt), .running(running), .done(done),
        .cfg_err(cfg_err), .desc_req(desc_req), .irq(irq)
    );

    function automatic logic [CW-1:0] eff(input logic [CW-1:0] c);
        return (c == '0) ? '1 : c;
    endfunction

    function automatic logic [AW-1:0] sext(input logic signed [MW-1:0] v);
        return {{(AW-MW){v[MW-1]}}, v};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(cur_addr == ea, req, "cur_addr", cur_addr, ea);
        chk(cur_xcnt == ex, req, "cur_xcnt", cur_xcnt, ex);
        chk(cur_ycnt == ey, req, "cur_ycnt", cur_ycnt, ey);
        chk(running == erun, req, "running", running, erun);
        chk(done == edone, req, "done", done, edone);
        chk(cfg_err == ecfg, req, "cfg_err", cfg_err, ecfg);
        chk(desc_req == ereq, req, "desc_req", desc_req, ereq);
        chk(elem_rdy == (erun && !ereq), req, "elem_rdy", elem_rdy, erun && !ereq);
        chk(irq == eirq, "R4", "irq", irq, eirq);
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [CW-1:0] xc,
                           input logic signed [MW-1:0] xm, input logic [CW-1:0] yc,
                           input logic signed [MW-1:0] ym, input logic d2,
                           input logic ie, input logic [1:0] fl, input logic [1:0] es);
        int mag;
        bit badc;
        @(negedge clk);
        prog_addr = a; prog_xcnt = xc; prog_xmod = xm; prog_ycnt = yc;
        prog_ymod = ym; prog_two_d = d2; prog_irq_en = ie; prog_flow = fl;
        prog_esize = es; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        mag = int'(xm);
        if (mag < 0) mag = -mag;
        badc = (es == 2'd3) || (mag != (1 << es));
        ea = a; ex = eff(xc); ey = eff(yc); exprog = eff(xc);
        m2d = d2; mien = ie; mflow = fl; mxm = xm; mym = ym;
        ecfg = badc; erun = !badc; edone = 1'b0; ereq = 1'b0; eirq = 1'b0;
        check_all(badc ? "R7" : "R1");
    endtask

    task automatic do_step(input string ign_tag);
        string tag;
        @(negedge clk);
        elem_stb = 1'b1;
        @(negedge clk);
        elem_stb = 1'b0;
        tag = ign_tag;
        eirq = 1'b0;
        if (erun && !ereq) begin
            if (ex == 1) begin
                eirq = mien;
                if (m2d && ey > 1) begin
                    ey = ey - 1; ex = exprog; ea = ea + sext(mym); tag = "R3";
                end else begin
                    ea = ea + sext(mxm); ex = '0;
                    if (mflow == 2'b00) begin
                        erun = 1'b0; edone = 1'b1; tag = "R5";
                    end else begin
                        ereq = 1'b1; tag = "R6";
                    end
                end
            end else begin
                ea = ea + sext(mxm); ex = ex - 1; tag = "R2";
            end
        end
        check_all(tag);
    endtask

    task automatic do_halt();
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        erun = 1'b0; ereq = 1'b0; eirq = 1'b0;
        check_all("R8");
    endtask

    initial begin
        ea = '0; ex = '0; ey = '0; exprog = '0;
        erun = 0; edone = 0; ecfg = 0; ereq = 0; eirq = 0;
        m2d = 0; mien = 0; mflow = '0; mxm = '0; mym = '0;
        repeat (3) @(negedge clk);
        check_all("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9");

        // R2 R3 R4 R5 R6: whole blocks over sizes, signs, counts, modes.
        for (int es = 0; es < 3; es++)
            for (int sg = 0; sg < 2; sg++)
                for (int xc = 0; xc < 8; xc++)
                    for (int yc = 1; yc < 4; yc++)
                        for (int d = 0; d < 2; d++)
                            for (int fl = 0; fl < 2; fl++) begin
                                logic signed [MW-1:0] xm;
                                logic signed [MW-1:0] ym;
                                int n;
                                xm = sg ? MW'(-(1 << es)) : MW'(1 << es);
                                ym = MW'(17 - xc * 5 + yc);
                                do_load(AW'(16'hFFF0 + es * 256 + xc * 16), CW'(xc), xm,
                                        CW'(yc), ym, d[0], xc[0] ^ d[0],
                                        fl ? 2'(1 + (xc % 3)) : 2'b00, 2'(es));
                                n = d ? int'(eff(CW'(xc))) * yc : int'(eff(CW'(xc)));
                                for (int k = 0; k < n; k++) do_step("R6");
                                do_step("R6");
                            end

        // R7: every size code against small strides.
        for (int es = 0; es < 4; es++)
            for (int xm = -6; xm <= 6; xm++) begin
                do_load(16'h0100, 3'd2, MW'(xm), 3'd1, 8'sd0, 1'b0, 1'b1, 2'b00, 2'(es));
                do_step("R7");
            end

        // R8: halt in mid-row, then a strobe that must be ignored.
        do_load(16'h0200, 3'd5, 8'sd2, 3'd2, -8'sd3, 1'b1, 1'b1, 2'b00, 2'd1);
        do_step("R8");
        do_step("R8");
        do_halt();
        do_step("R8");

        // R8: halt while a descriptor is requested; done stays from before.
        do_load(16'h0300, 3'd1, -8'sd4, 3'd1, 8'sd0, 1'b0, 1'b0, 2'b11, 2'd2);
        do_step("R6");
        do_halt();
        do_step("R8");

        // R1: a load right after a request restarts the channel.
        do_load(16'h0400, 3'd1, 8'sd1, 3'd1, 8'sd0, 1'b0, 1'b0, 2'b01, 2'd0);
        do_step("R6");
        do_load(16'h0500, 3'd3, 8'sd1, 3'd2, 8'sd9, 1'b1, 1'b0, 2'b00, 2'd0);
        do_step("R2");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule